// File: doc/BRIEF.md
# Debug-Port POST Code Packer

This block collects byte-sized writes aimed at a debug port and rebuilds them into 32-bit power-on self-test codes. Every write carries one data byte and a 2-bit lane number telling which byte of the 32-bit code it belongs to. Writes are queued in a 16-entry FIFO. When the consumer side raises its service request and the FIFO holds entries, the block starts a drain burst. The burst pops the queued entries one per clock and merges them into codes. Each finished code is presented for a single cycle with a valid strobe.

A code ends when the entry after it in the same burst has lane 0, or when the burst runs out of entries. A code may therefore hold one to four bytes, and no fixed byte count is assumed. Three status outputs report the queue state: FIFO-not-empty, a sticky overflow flag and a sticky write-seen flag. The two sticky flags are cleared by write-one strobes. Decoding the bus that produces the writes, and showing the codes anywhere, are left to neighbouring logic.

Top module: `postcode_packer`

## Requirements
- R1: A popped entry places its 8-bit data byte at code bits [8*lane+7 : 8*lane], where lane is the 2-bit `wr_offs` value. It is OR-ed into the code being built, so two entries with the same lane OR their bytes together.
- R2: Within a burst, if the next queued entry has lane 0, the code being built is emitted together with the current entry's byte. The following entry then starts a fresh code from zero.
- R3: The final entry of a burst always emits the code being built, whatever the lane of any later entry. The next burst starts its code from zero.
- R4: A burst starts on a clock edge where `drain_go` is high, the block is idle and the FIFO is non-empty. It then pops min(stored entries, 16) entries, one per clock, in write order.
- R5: Every code is reported by `code_valid` high for exactly one cycle, with `code_data` valid in that cycle. A burst of n entries with k code ends produces exactly k pulses.
- R6: `fifo_nempty` is high exactly while at least one entry is stored.
- R7: A write that arrives while 16 entries are stored is dropped, the stored entries are kept unchanged, and `ovf_flag` is set on the next cycle.
- R8: `ovf_flag` is cleared by `clr_ovf`=1. A new overflowing write in the same cycle wins, and the flag stays set.
- R9: `wpend_flag` is set by every write, dropped writes included. It is cleared by `clr_wpend`=1, and a write in the same cycle wins.
- R10: After reset, `code_valid`, `fifo_nempty`, `ovf_flag` and `wpend_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Debug-port write strobe, one entry per cycle |
| wr_data | input | 8 | Data byte of the write |
| wr_offs | input | 2 | Byte lane of the write within the 32-bit code |
| drain_go | input | 1 | Service request; allows a burst to start |
| clr_ovf | input | 1 | Write-one-to-clear strobe for the overflow flag |
| clr_wpend | input | 1 | Write-one-to-clear strobe for the write-seen flag |
| code_valid | output | 1 | One-cycle strobe marking a finished code |
| code_data | output | 32 | Finished code, valid with `code_valid` |
| fifo_nempty | output | 1 | FIFO holds at least one entry |
| ovf_flag | output | 1 | Sticky: a write was dropped because the FIFO was full |
| wpend_flag | output | 1 | Sticky: at least one write has arrived |

## Verification
The assertions assume that every input is a synchronous level sampled at the rising edge. Each `wr_en` cycle is taken as one distinct write, and each strobe cycle as one request. Reset is assumed to be held long enough to clear all state. The bench changes every input only on falling edges. For the packing sweeps, it loads the FIFO completely with `drain_go` low and only then raises `drain_go` for a single cycle, so each burst sees a known, fixed set of entries. Only the overflow case writes into a full queue, and it does so with no burst running.

// File: rtl/pcq_pkg.sv
package pcq_pkg;

    // Byte and lane geometry of one debug-port write
    localparam int DATA_W = 8;
    localparam int OFFS_W = 2;
    localparam int LANES  = 1 << OFFS_W;
    localparam int CODE_W = DATA_W * LANES;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [OFFS_W-1:0] offs;
    } entry_t;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

endpackage

// File: rtl/pcq_fifo.sv
module pcq_fifo
    import pcq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  entry_t                     din,
    input  logic                       pop,
    output entry_t                     head,
    output logic [OFFS_W-1:0]          after_offs,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);

    // DEPTH must be a power of two so the pointers wrap on their own
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   wp;
        logic [PTR_W-1:0]   rp;
        logic [CNT_W-1:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok, pop_ok;
    entry_t   nxt_e;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp           = st_q.wp + PTR_W'(1);
        end
        if (pop_ok) begin
            st_d.rp = st_q.rp + PTR_W'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head       = st_q.mem[st_q.rp];
    assign nxt_e      = st_q.mem[st_q.rp + PTR_W'(1)];
    assign after_offs = nxt_e.offs;
    assign count      = st_q.cnt;
    assign full       = (st_q.cnt == CNT_W'(DEPTH));

    // R7: occupancy never exceeds the storage
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R7: a write into a full queue with no pop leaves it full
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CNT_W'(DEPTH)));

    // R6: a write into an empty queue makes it non-empty
    assert_push_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (count == '0)) |=> (count != '0));

endmodule

// File: rtl/pcq_pack.sv
module pcq_pack
    import pcq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int BURST_MAX = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  entry_t                     head,
    input  logic [OFFS_W-1:0]          after_offs,
    output logic                       pop,
    output logic                       code_valid,
    output logic [CODE_W-1:0]          code_data
);

    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LEFT_W = $clog2(BURST_MAX + 1);

    typedef struct packed {
        phase_e            ph;
        logic [LEFT_W-1:0] left;
        logic [CODE_W-1:0] acc;
        logic [CODE_W-1:0] code;
        logic              vld;
    } pack_st_t;

    pack_st_t          st_d, st_q;
    logic [CODE_W-1:0] ins;
    logic [CODE_W-1:0] merged;
    logic [CNT_W-1:0]  take;
    logic              last_one;
    logic              boundary;

    // Steer the head byte into its lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ins[l*DATA_W +: DATA_W] =
            (head.offs == OFFS_W'(l)) ? head.data : '0;
    end

    assign merged   = st_q.acc | ins;
    assign take     = (count > CNT_W'(BURST_MAX)) ? CNT_W'(BURST_MAX) : count;
    assign last_one = (st_q.left == LEFT_W'(1));
    assign boundary = last_one || (after_offs == '0);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        pop      = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (go && (count != '0)) begin
                    st_d.ph   = PH_DRAIN;
                    st_d.left = LEFT_W'(take);
                    st_d.acc  = '0;
                end
            end
            PH_DRAIN: begin
                pop       = 1'b1;
                st_d.left = st_q.left - LEFT_W'(1);
                if (boundary) begin
                    st_d.code = merged;
                    st_d.vld  = 1'b1;
                    st_d.acc  = '0;
                end else begin
                    st_d.acc  = merged;
                end
                if (last_one) begin
                    st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_valid = st_q.vld;
    assign code_data  = st_q.code;

    // R4: the drain never pops an empty queue
    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    // R4: the burst budget stays within its limit
    assert_left_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= LEFT_W'(BURST_MAX));

    // R5: a code strobe only follows a draining cycle
    assert_valid_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(st_q.ph == PH_DRAIN));

    // R3: leaving the burst always comes with a code strobe
    assert_last_emits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DRAIN && last_one) |=> code_valid);

endmodule

// File: rtl/pcq_flags.sv
module pcq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic full,
    input  logic clr_ovf,
    input  logic clr_wpend,
    output logic ovf_flag,
    output logic wpend_flag
);

    typedef struct packed {
        logic ovf;
        logic wpend;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     drop;

    assign drop = wr_en && full;

    always_comb begin
        st_d = st_q;
        if (clr_ovf) begin
            st_d.ovf = 1'b0;
        end
        if (drop) begin
            st_d.ovf = 1'b1;
        end
        if (clr_wpend) begin
            st_d.wpend = 1'b0;
        end
        if (wr_en) begin
            st_d.wpend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_flag   = st_q.ovf;
    assign wpend_flag = st_q.wpend;

    // R7: a dropped write raises the overflow flag
    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> ovf_flag);

    // R8: a clear with no competing drop lowers the flag
    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !(wr_en && full)) |=> !ovf_flag);

    // R9: any write raises the write-seen flag
    assert_wpend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wpend_flag);

    // R9: without a write or clear the flag holds its value
    assert_wpend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_wpend) |=> $stable(wpend_flag));

endmodule

// File: rtl/postcode_packer.sv
module postcode_packer
    import pcq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int BURST_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        wr_offs,
    input  logic              drain_go,
    input  logic              clr_ovf,
    input  logic              clr_wpend,
    output logic              code_valid,
    output logic [31:0]       code_data,
    output logic              fifo_nempty,
    output logic              ovf_flag,
    output logic              wpend_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    entry_t             din;
    entry_t             head;
    logic [OFFS_W-1:0]  after_offs;
    logic [CNT_W-1:0]   count;
    logic               full;
    logic               pop;

    assign din.data = wr_data;
    assign din.offs = wr_offs;

    pcq_fifo #(
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_en),
        .din        (din),
        .pop        (pop),
        .head       (head),
        .after_offs (after_offs),
        .count      (count),
        .full       (full)
    );

    pcq_pack #(
        .DEPTH    (DEPTH),
        .BURST_MAX(BURST_MAX)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (drain_go),
        .count      (count),
        .head       (head),
        .after_offs (after_offs),
        .pop        (pop),
        .code_valid (code_valid),
        .code_data  (code_data)
    );

    pcq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .full       (full),
        .clr_ovf    (clr_ovf),
        .clr_wpend  (clr_wpend),
        .ovf_flag   (ovf_flag),
        .wpend_flag (wpend_flag)
    );

    assign fifo_nempty = (count != '0);

    // R6: the queue cannot drain to empty without a pop
    assert_nempty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_nempty && !pop) |=> fifo_nempty);

endmodule

// File: tb/sim_postcode_packer.sv
`timescale 1ns/1ps
module sim_postcode_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  wr_offs = '0;
    logic        drain_go = 1'b0;
    logic        clr_ovf = 1'b0;
    logic        clr_wpend = 1'b0;
    logic        code_valid;
    logic [31:0] code_data;
    logic        fifo_nempty;
    logic        ovf_flag;
    logic        wpend_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ngot = 0;
    logic [31:0] got [0:255];

    always #4 clk = ~clk;

    postcode_packer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_offs(wr_offs), .drain_go(drain_go), .clr_ovf(clr_ovf),
        .clr_wpend(clr_wpend), .code_valid(code_valid), .code_data(code_data),
        .fifo_nempty(fifo_nempty), .ovf_flag(ovf_flag), .wpend_flag(wpend_flag)
    );

    // Collect every strobed code
    always @(negedge clk) begin
        if (rst_n && code_valid) begin
            got[ngot % 256] = code_data;
            ngot = ngot + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic [1:0] o);
        wr_data = d;
        wr_offs = o;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic drain(input int n);
        drain_go = 1'b1;
        @(negedge clk);
        drain_go = 1'b0;
        repeat (n + 3) @(negedge clk);
    endtask

    // Load n entries, drain them, compare against the arithmetic packing rule
    task automatic run_burst(input int n, input logic [7:0] dv [16],
                             input logic [1:0] ov [16], input string tag);
        logic [31:0] exp [16];
        int          ne = 0;
        int          base;
        logic [31:0] acc = '0;
        for (int i = 0; i < n; i++) begin
            acc = acc | (32'(dv[i]) << (8 * int'(ov[i])));    // R1
            if (i == n - 1 || ov[i+1] == 2'd0) begin          // R3 / R2
                exp[ne] = acc;
                ne = ne + 1;
                acc = '0;
            end
        end
        for (int i = 0; i < n; i++) put(dv[i], ov[i]);
        base = ngot;
        drain(n);
        chk({tag, " R5 code count"}, 32'(ngot - base), 32'(ne));
        if (ngot - base == ne) begin
            for (int k = 0; k < ne; k++)
                chk({tag, " R2 code value"}, got[(base + k) % 256], exp[k]);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] dv [16];
        logic [1:0] ov [16];
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 code_valid", 32'(code_valid), 32'd0);
        chk("R10 fifo_nempty", 32'(fifo_nempty), 32'd0);
        chk("R10 ovf_flag", 32'(ovf_flag), 32'd0);
        chk("R10 wpend_flag", 32'(wpend_flag), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: one entry makes the queue non-empty; a drain empties it
        put(8'h3C, 2'd0);
        chk("R6 nempty after write", 32'(fifo_nempty), 32'd1);
        chk("R9 wpend after write", 32'(wpend_flag), 32'd1);
        drain(1);
        chk("R6 nempty after drain", 32'(fifo_nempty), 32'd0);
        chk("R1 single byte code", got[(ngot - 1) % 256], 32'h0000003C);

        // Exhaustive sweep of lane sequences of length 1..4 (R1 R2 R3)
        for (int len = 1; len <= 4; len++) begin
            for (int pat = 0; pat < (1 << (2 * len)); pat++) begin
                for (int i = 0; i < len; i++) begin
                    ov[i] = 2'((pat >> (2 * i)) & 3);
                    dv[i] = 8'(len * 37 + i * 91 + pat * 5 + 1);
                end
                run_burst(len, dv, ov, "sweep");
            end
        end

        // R4: a full 16-entry burst with mixed lanes
        for (int i = 0; i < 16; i++) begin
            ov[i] = 2'((i * 7 + 3) % 4);
            dv[i] = 8'(8'hC0 + i);
        end
        run_burst(16, dv, ov, "R4 full burst");

        // R3: a code split across two bursts restarts from zero
        for (int i = 0; i < 2; i++) begin
            ov[i] = 2'(i + 2);
            dv[i] = 8'(8'h71 + i);
        end
        run_burst(2, dv, ov, "R3 split tail");

        // R7 overflow: fill, then write once more
        clr_ovf = 1'b1; clr_wpend = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0; clr_wpend = 1'b0;
        chk("R9 wpend cleared", 32'(wpend_flag), 32'd0);
        for (int i = 0; i < 16; i++) put(8'(8'hA0 + i), 2'(i % 4));
        chk("R7 no overflow when just full", 32'(ovf_flag), 32'd0);
        put(8'h5A, 2'd0);
        chk("R7 overflow set", 32'(ovf_flag), 32'd1);
        // R8: overflowing write and clear in the same cycle
        wr_data = 8'h5B; wr_offs = 2'd0; wr_en = 1'b1; clr_ovf = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; clr_ovf = 1'b0;
        chk("R8 set wins over clear", 32'(ovf_flag), 32'd1);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        chk("R8 clear", 32'(ovf_flag), 32'd0);
        // R9: write and clear in the same cycle (write is dropped, still counts)
        wr_data = 8'h5C; wr_en = 1'b1; clr_wpend = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; clr_wpend = 1'b0;
        chk("R9 set wins over clear", 32'(wpend_flag), 32'd1);
        clr_wpend = 1'b1;
        @(negedge clk);
        clr_wpend = 1'b0;
        chk("R9 clear", 32'(wpend_flag), 32'd0);
        // R7: stored entries survive, dropped ones never appear
        begin
            int base;
            base = ngot;
            drain(16);
            chk("R7 kept code count", 32'(ngot - base), 32'd4);
            if (ngot - base == 4) begin
                for (int k = 0; k < 4; k++)
                    chk("R7 kept code value", got[(base + k) % 256],
                        {8'(8'hA3 + 4*k), 8'(8'hA2 + 4*k), 8'(8'hA1 + 4*k), 8'(8'hA0 + 4*k)});
            end
            chk("R7 dropped write absent", 32'(fifo_nempty), 32'd0);
        end

        // R4: drain_go low keeps entries queued
        put(8'h11, 2'd0);
        repeat (5) @(negedge clk);
        chk("R4 no burst without request", 32'(fifo_nempty), 32'd1);
        drain(1);
        chk("R4 burst after request", 32'(fifo_nempty), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule